// File: doc/BRIEF.md
# Twelve-Channel Doorbell Mailbox

This block passes short messages between a host processor and a remote controller. The host has two register ports. A data port reaches a shared message store, and a control port reaches the doorbell and status bits. The remote side has its own data port into the same store. It also has a vector of pending doorbells and per-channel strobes to acknowledge a message or to post one back. Each of the twelve channels owns a fixed outbound window and a fixed inbound window inside the message store. The windows have different sizes, and the inbound windows are never larger than eight words.

To send a message, the host writes whole 32-bit words into a channel's outbound window in ascending order and then rings that channel's doorbell. The remote side sees the pending bit, reads the words and acknowledges. The host polls the transmit status until the bit drops to 0. To reply, the remote side fills the channel's inbound window and posts. This raises the receive status bit, and a single interrupt line shared by all channels rises with it. The host reads the inbound words and clears the bit.

Each channel is a four-state machine. The states are CH_IDLE, CH_TX_BUSY (outbound pending), CH_RX_FULL (inbound held) and CH_BOTH. The transitions are DOORBELL (host set), ACK (remote acknowledge), POST (remote post) and CLEAR (host clear). Transmit and receive move independently inside that product.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset every transmit and receive status bit is 0, `irq` is 0, `tx_pending` is 0, and every read port returns 0. The message store is also zero, so any word read after reset returns 0 until it is written.
- R2: A host control write to byte offset 0x04 sets transmit status bit n (DOORBELL) for each 1 in bit n of the write data. The change shows on `tx_pending` after that clock edge. A read of offset 0x00 returns the transmit status in bits 11:0. Zero bits in the write data have no effect.
- R3: `r_ack[n]` clears transmit status bit n (ACK). When a DOORBELL and an ACK hit the same bit in the same cycle, the bit ends up set. Without either, the bit holds.
- R4: `r_post[n]` sets receive status bit n (POST). A read of offset 0x78 returns the receive status in bits 11:0.
- R5: A host control write to offset 0x74 clears receive status bit n (CLEAR) for each 1 in bit n of the write data. Zero bits have no effect. When a POST and a CLEAR hit the same bit in the same cycle, the bit ends up set.
- R6: `irq` is 1 exactly while at least one receive status bit is 1. It follows the status after the same clock edge.
- R7: Control reads of offsets 0x04 and 0x74, and of any offset other than 0x00 and 0x78, return 0. Host writes to 0x00 and 0x78 change nothing.
- R8: Data ports use word addresses (byte offset / 4). A read returns the stored word one cycle after the address is presented. Outbound windows cover words 0–55 (bytes 0x000–0x0DF). Inbound windows cover words 56–91 (bytes 0x0E0–0x16F). A host write into an outbound word can be read by both sides. A remote write into an inbound word can likewise be read by both sides.
- R9: Host data writes into inbound words and remote data writes into outbound words are ignored.
- R10: Word addresses 92 and above lie outside every window. Writes there are ignored and reads there return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hc_we | input | 1 | Host control write strobe |
| hc_addr | input | 7 | Host control byte offset |
| hc_wdata | input | 32 | Host control write data |
| hc_rdata | output | 32 | Host control read data, one cycle after address |
| hd_we | input | 1 | Host data write strobe |
| hd_addr | input | 7 | Host data word address |
| hd_wdata | input | 32 | Host data write word |
| hd_rdata | output | 32 | Host data read word, one cycle after address |
| rd_we | input | 1 | Remote data write strobe |
| rd_addr | input | 7 | Remote data word address |
| rd_wdata | input | 32 | Remote data write word |
| rd_rdata | output | 32 | Remote data read word, one cycle after address |
| r_ack | input | 12 | Remote per-channel acknowledge |
| r_post | input | 12 | Remote per-channel post |
| tx_pending | output | 12 | Transmit status vector toward the remote side |
| irq | output | 1 | Shared host interrupt |

## Verification
The bound checker tests, on every cycle, the following rules:
- a doorbell raises the bits it names;
- an acknowledge without a same-cycle doorbell drops its bit;
- transmit status holds when neither arrives;
- a post always leaves `irq` high;
- `irq` rises only after a post;
- set and clear offsets read 0;
- out-of-range data reads return 0.

Two further behaviours need the bench's scenarios, because they depend on stored contents and on the order of operations. The first is that each side reads back what the owning side wrote, while writes into the other side's windows leave nothing behind. The second is that CLEAR loses to a same-cycle POST.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    localparam int NCH = 12;
    localparam int DW  = 32;
    localparam int AW  = 7;
    localparam int CW  = 7;

    // per-channel windows, byte offsets and byte lengths
    localparam int TX_OFF [NCH] = '{'h000, 'h010, 'h030, 'h03C, 'h054, 'h078,
                                    'h088, 'h0A0, 'h0B8, 'h0BC, 'h0CC, 'h0DC};
    localparam int TX_LEN [NCH] = '{16, 32, 12, 24, 36, 16, 24, 24, 4, 16, 16, 4};
    localparam int RX_OFF [NCH] = '{'h0E0, 'h0F0, 'h110, 'h114, 'h118, 'h11C,
                                    'h12C, 'h130, 'h148, 'h158, 'h15C, 'h16C};
    localparam int RX_LEN [NCH] = '{16, 32, 4, 4, 4, 16, 4, 24, 16, 4, 16, 4};

    function automatic int store_words();
        int top;
        top = 0;
        for (int i = 0; i < NCH; i++) begin
            if ((TX_OFF[i] + TX_LEN[i]) / 4 > top) top = (TX_OFF[i] + TX_LEN[i]) / 4;
            if ((RX_OFF[i] + RX_LEN[i]) / 4 > top) top = (RX_OFF[i] + RX_LEN[i]) / 4;
        end
        return top;
    endfunction

    localparam int NWORDS = store_words();

    localparam logic [CW-1:0] OFS_TXSTS = 7'h00;
    localparam logic [CW-1:0] OFS_DBSET = 7'h04;
    localparam logic [CW-1:0] OFS_RXCLR = 7'h74;
    localparam logic [CW-1:0] OFS_RXSTS = 7'h78;

    typedef enum logic [1:0] {
        CH_IDLE    = 2'd0,
        CH_TX_BUSY = 2'd1,
        CH_RX_FULL = 2'd2,
        CH_BOTH    = 2'd3
    } ch_state_e;

endpackage

// File: rtl/mbox_win_decode.sv
module mbox_win_decode
    import mbox_pkg::*;
#(
    parameter int AWID = AW
) (
    input  logic [AWID-1:0] waddr,
    output logic            in_tx,
    output logic            in_rx
);

    logic [NCH-1:0] tx_hit;
    logic [NCH-1:0] rx_hit;
    logic [31:0]    wa;

    assign wa = 32'(waddr);

    for (genvar g = 0; g < NCH; g++) begin : g_win
        localparam int TLO = TX_OFF[g] / 4;
        localparam int THI = (TX_OFF[g] + TX_LEN[g]) / 4;
        localparam int RLO = RX_OFF[g] / 4;
        localparam int RHI = (RX_OFF[g] + RX_LEN[g]) / 4;
        assign tx_hit[g] = (wa >= 32'(TLO)) && (wa < 32'(THI));
        assign rx_hit[g] = (wa >= 32'(RLO)) && (wa < 32'(RHI));
    end

    assign in_tx = |tx_hit;
    assign in_rx = |rx_hit;

endmodule

// File: rtl/mbox_msg_ram.sv
module mbox_msg_ram #(
    parameter int DEPTH = 92,
    parameter int WIDTH = 32,
    parameter int AWID  = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             a_we,
    input  logic [AWID-1:0]  a_addr,
    input  logic [WIDTH-1:0] a_wdata,
    output logic [WIDTH-1:0] a_rdata,
    input  logic             b_we,
    input  logic [AWID-1:0]  b_addr,
    input  logic [WIDTH-1:0] b_wdata,
    output logic [WIDTH-1:0] b_rdata
);

    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            a_rdata <= '0;
            b_rdata <= '0;
        end else begin
            a_rdata <= (32'(a_addr) < 32'(DEPTH)) ? mem[a_addr] : '0;
            b_rdata <= (32'(b_addr) < 32'(DEPTH)) ? mem[b_addr] : '0;
            if (a_we && (32'(a_addr) < 32'(DEPTH))) mem[a_addr] <= a_wdata;
            if (b_we && (32'(b_addr) < 32'(DEPTH))) mem[b_addr] <= b_wdata;
        end
    end

endmodule

// File: rtl/mbox_chan_fsm.sv
module mbox_chan_fsm
    import mbox_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic ack_i,
    input  logic post_i,
    input  logic clr_i,
    output logic tx_o,
    output logic rx_o
);

    ch_state_e state_q, state_d;
    logic      tx_nxt, rx_nxt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    // outputs from state
    always_comb begin
        tx_o = 1'b0;
        rx_o = 1'b0;
        unique case (state_q)
            CH_IDLE:    ;
            CH_TX_BUSY: tx_o = 1'b1;
            CH_RX_FULL: rx_o = 1'b1;
            CH_BOTH: begin
                tx_o = 1'b1;
                rx_o = 1'b1;
            end
            default: ;
        endcase
    end

    // DOORBELL beats ACK, POST beats CLEAR
    always_comb begin
        tx_nxt = set_i  | (tx_o & ~ack_i);
        rx_nxt = post_i | (rx_o & ~clr_i);
        unique case ({tx_nxt, rx_nxt})
            2'b00:   state_d = CH_IDLE;
            2'b10:   state_d = CH_TX_BUSY;
            2'b01:   state_d = CH_RX_FULL;
            2'b11:   state_d = CH_BOTH;
            default: state_d = CH_IDLE;
        endcase
    end

endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
    import mbox_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           hc_we,
    input  logic [CW-1:0]  hc_addr,
    input  logic [DW-1:0]  hc_wdata,
    output logic [DW-1:0]  hc_rdata,
    input  logic           hd_we,
    input  logic [AW-1:0]  hd_addr,
    input  logic [DW-1:0]  hd_wdata,
    output logic [DW-1:0]  hd_rdata,
    input  logic           rd_we,
    input  logic [AW-1:0]  rd_addr,
    input  logic [DW-1:0]  rd_wdata,
    output logic [DW-1:0]  rd_rdata,
    input  logic [NCH-1:0] r_ack,
    input  logic [NCH-1:0] r_post,
    output logic [NCH-1:0] tx_pending,
    output logic           irq
);

    logic [NCH-1:0] set_v, clr_v, tx_v, rx_v;
    logic           h_in_tx, h_in_rx, r_in_tx, r_in_rx;
    logic           h_hit_q, r_hit_q;
    logic [DW-1:0]  h_raw, r_raw;

    assign set_v = (hc_we && hc_addr == OFS_DBSET) ? hc_wdata[NCH-1:0] : '0;
    assign clr_v = (hc_we && hc_addr == OFS_RXCLR) ? hc_wdata[NCH-1:0] : '0;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        mbox_chan_fsm u_fsm (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (set_v[c]),
            .ack_i  (r_ack[c]),
            .post_i (r_post[c]),
            .clr_i  (clr_v[c]),
            .tx_o   (tx_v[c]),
            .rx_o   (rx_v[c])
        );
    end

    assign tx_pending = tx_v;
    assign irq        = |rx_v;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hc_rdata <= '0;
        end else begin
            unique case (hc_addr)
                OFS_TXSTS: hc_rdata <= DW'(tx_v);
                OFS_RXSTS: hc_rdata <= DW'(rx_v);
                default:   hc_rdata <= '0;
            endcase
        end
    end

    mbox_win_decode #(.AWID(AW)) u_hdec (
        .waddr (hd_addr),
        .in_tx (h_in_tx),
        .in_rx (h_in_rx)
    );

    mbox_win_decode #(.AWID(AW)) u_rdec (
        .waddr (rd_addr),
        .in_tx (r_in_tx),
        .in_rx (r_in_rx)
    );

    mbox_msg_ram #(.DEPTH(NWORDS), .WIDTH(DW), .AWID(AW)) u_ram (
        .clk     (clk),
        .rst_n   (rst_n),
        .a_we    (hd_we && h_in_tx),
        .a_addr  (hd_addr),
        .a_wdata (hd_wdata),
        .a_rdata (h_raw),
        .b_we    (rd_we && r_in_rx),
        .b_addr  (rd_addr),
        .b_wdata (rd_wdata),
        .b_rdata (r_raw)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_hit_q <= 1'b0;
            r_hit_q <= 1'b0;
        end else begin
            h_hit_q <= h_in_tx | h_in_rx;
            r_hit_q <= r_in_tx | r_in_rx;
        end
    end

    assign hd_rdata = h_hit_q ? h_raw : '0;
    assign rd_rdata = r_hit_q ? r_raw : '0;

endmodule

// File: rtl/mbox_checker.sv
module mbox_checker
    import mbox_pkg::*;
(
    input logic           clk,
    input logic           rst_n,
    input logic           hc_we,
    input logic [CW-1:0]  hc_addr,
    input logic [DW-1:0]  hc_wdata,
    input logic [DW-1:0]  hc_rdata,
    input logic [AW-1:0]  hd_addr,
    input logic [DW-1:0]  hd_rdata,
    input logic [NCH-1:0] r_ack,
    input logic [NCH-1:0] r_post,
    input logic [NCH-1:0] tx_pending,
    input logic           irq
);

    logic [NCH-1:0] ck_set;
    assign ck_set = (hc_we && hc_addr == OFS_DBSET) ? hc_wdata[NCH-1:0] : '0;

    a_r2_doorbell_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (|ck_set) |=> ((tx_pending & $past(ck_set)) == $past(ck_set)));

    a_r3_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (|(r_ack & ~ck_set)) |=> ((tx_pending & $past(r_ack & ~ck_set)) == '0));

    a_r3_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!(|ck_set) && !(|r_ack)) |=> $stable(tx_pending));

    a_r4_post_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (|r_post) |=> irq);

    a_r6_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(|r_post));

    a_r7_wo_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (hc_addr == OFS_DBSET || hc_addr == OFS_RXCLR) |=> (hc_rdata == '0));

    a_r10_oob_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(hd_addr) >= 32'(NWORDS)) |=> (hd_rdata == '0));

endmodule

bind ipc_mailbox mbox_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hc_we      (hc_we),
    .hc_addr    (hc_addr),
    .hc_wdata   (hc_wdata),
    .hc_rdata   (hc_rdata),
    .hd_addr    (hd_addr),
    .hd_rdata   (hd_rdata),
    .r_ack      (r_ack),
    .r_post     (r_post),
    .tx_pending (tx_pending),
    .irq        (irq)
);

// File: tb/ipc_mailbox_tb.sv
`timescale 1ns/1ps
module ipc_mailbox_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hc_we = 1'b0;
    logic [6:0]  hc_addr = '0;
    logic [31:0] hc_wdata = '0;
    logic [31:0] hc_rdata;
    logic        hd_we = 1'b0;
    logic [6:0]  hd_addr = '0;
    logic [31:0] hd_wdata = '0;
    logic [31:0] hd_rdata;
    logic        rd_we = 1'b0;
    logic [6:0]  rd_addr = '0;
    logic [31:0] rd_wdata = '0;
    logic [31:0] rd_rdata;
    logic [11:0] r_ack = '0;
    logic [11:0] r_post = '0;
    logic [11:0] tx_pending;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [11:0] m_tx = '0;
    logic [11:0] m_rx = '0;
    logic [31:0] m_mem [92];

    always #2 clk = ~clk;

    ipc_mailbox u_dut (.*);

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_ctl(logic [6:0] a);
        if (a == 7'h00) return {20'd0, m_tx};
        if (a == 7'h78) return {20'd0, m_rx};
        return 32'd0;
    endfunction

    function automatic logic [31:0] exp_dat(logic [6:0] a);
        return (a < 7'd92) ? m_mem[a] : 32'd0;
    endfunction

    task automatic idle_in();
        hc_we = 0; hd_we = 0; rd_we = 0; r_ack = '0; r_post = '0;
    endtask

    // one clock: predict, advance model, check after edge
    task automatic tick();
        logic [31:0] e_hc, e_hd, e_rd;
        logic [11:0] setv, clrv;
        e_hc = exp_ctl(hc_addr);
        e_hd = exp_dat(hd_addr);
        e_rd = exp_dat(rd_addr);
        setv = (hc_we && hc_addr == 7'h04) ? hc_wdata[11:0] : '0;
        clrv = (hc_we && hc_addr == 7'h74) ? hc_wdata[11:0] : '0;
        m_tx = setv | (m_tx & ~r_ack);
        m_rx = r_post | (m_rx & ~clrv);
        if (hd_we && hd_addr < 7'd56) m_mem[hd_addr] = hd_wdata;
        if (rd_we && rd_addr >= 7'd56 && rd_addr < 7'd92) m_mem[rd_addr] = rd_wdata;
        @(posedge clk);
        #1;
        check("R7/R2/R4 hc_rdata", hc_rdata, e_hc);
        check("R8/R9/R10 hd_rdata", hd_rdata, e_hd);
        check("R8/R9/R10 rd_rdata", rd_rdata, e_rd);
        check("R2/R3 tx_pending", {20'd0, tx_pending}, {20'd0, m_tx});
        check("R6 irq", {31'd0, irq}, {31'd0, |m_rx});
        idle_in();
    endtask

    function automatic logic [6:0] pick_ctl();
        case ($urandom % 6)
            0: return 7'h00;
            1: return 7'h04;
            2: return 7'h74;
            3: return 7'h78;
            default: return 7'($urandom);
        endcase
    endfunction

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 92; i++) m_mem[i] = '0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 irq reset", {31'd0, irq}, 32'd0);
        check("R1 tx_pending reset", {20'd0, tx_pending}, 32'd0);
        check("R1 hc_rdata reset", hc_rdata, 32'd0);
        rst_n = 1'b1;

        // R2: doorbell bits 3 and 11, zero bits ignored
        hc_we = 1; hc_addr = 7'h04; hc_wdata = 32'h0000_0808; tick();
        check("R2 doorbell", {20'd0, tx_pending}, 32'h808);
        hc_addr = 7'h00; tick();
        check("R2 status read", hc_rdata, 32'h808);
        // R3: set beats ack on bit 3, ack alone clears bit 11
        hc_we = 1; hc_addr = 7'h04; hc_wdata = 32'h8; r_ack = 12'h808; tick();
        check("R3 set wins / ack clears", {20'd0, tx_pending}, 32'h008);
        // R7: writes to status offsets ignored, set/clear read zero
        hc_we = 1; hc_addr = 7'h00; hc_wdata = 32'hFFF; tick();
        check("R7 status write ignored", {20'd0, tx_pending}, 32'h008);
        hc_addr = 7'h04; tick();
        check("R7 set reads zero", hc_rdata, 32'd0);
        // R4/R6: post bit 5
        r_post = 12'h020; tick();
        check("R6 irq on post", {31'd0, irq}, 32'd1);
        hc_addr = 7'h78; tick();
        check("R4 rx status read", hc_rdata, 32'h20);
        // R5: zero clear, then clear vs post, then clear
        hc_we = 1; hc_addr = 7'h74; hc_wdata = 32'h0; tick();
        check("R5 zero clear", {31'd0, irq}, 32'd1);
        hc_we = 1; hc_addr = 7'h74; hc_wdata = 32'h20; r_post = 12'h020; tick();
        check("R5 post wins", {31'd0, irq}, 32'd1);
        hc_we = 1; hc_addr = 7'h74; hc_wdata = 32'h20; tick();
        check("R5 R6 clear drops irq", {31'd0, irq}, 32'd0);
        // R8: host outbound word read by remote; R9: host inbound write ignored
        hd_we = 1; hd_addr = 7'd55; hd_wdata = 32'hCAFE_0055; tick();
        rd_addr = 7'd55; tick();
        check("R8 remote sees host word", rd_rdata, 32'hCAFE_0055);
        hd_we = 1; hd_addr = 7'd60; hd_wdata = 32'hDEAD_0060; tick();
        hd_addr = 7'd60; tick();
        check("R9 host inbound write ignored", hd_rdata, 32'd0);
        rd_we = 1; rd_addr = 7'd56; rd_wdata = 32'hBEEF_0056; tick();
        hd_addr = 7'd56; tick();
        check("R8 host sees remote word", hd_rdata, 32'hBEEF_0056);
        rd_we = 1; rd_addr = 7'd0; rd_wdata = 32'h1111_2222; tick();
        hd_addr = 7'd0; tick();
        check("R9 remote outbound write ignored", hd_rdata, 32'd0);
        // R10: out-of-range
        rd_we = 1; rd_addr = 7'd100; rd_wdata = 32'h5555_AAAA; tick();
        rd_addr = 7'd100; tick();
        check("R10 oob read zero", rd_rdata, 32'd0);

        // constrained random traffic
        for (int n = 0; n < 3000; n++) begin
            hc_we    = ($urandom % 3) == 0;
            hc_addr  = pick_ctl();
            hc_wdata = $urandom;
            hd_we    = ($urandom % 2) == 0;
            hd_addr  = 7'($urandom % 100);
            hd_wdata = $urandom;
            rd_we    = ($urandom % 2) == 0;
            rd_addr  = 7'($urandom % 100);
            rd_wdata = $urandom;
            r_ack    = 12'($urandom) & 12'($urandom);
            r_post   = 12'($urandom) & 12'($urandom) & 12'($urandom);
            tick();
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule